// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Responder

This block is the device side of a 64-word by 16-bit serial EEPROM that a host drives by bit-banging one control register. Each register write carries chip select, serial clock and serial data-in; the block watches for edges between one write and the next. It shifts in a 3-bit opcode and a 6-bit word address, then streams the addressed word out most significant bit first on the data-out bit of the register read view. The output bit position is one running counter, so clocking past the end of a word carries on into the next word, and it wraps from the last word to word 0.

A second, parallel read port returns a whole word in one request for register-based word reads. The contents are fixed and computed at elaboration: a station address, a deterministic fill pattern, and a final word that makes the 16-bit sum of all words a fixed signature. Opcodes other than read are decoded and ignored. The parallel port accepts a request in every cycle and exerts no back-pressure. The reply is a one-cycle pulse that the requester must take when it appears.

Top module: `uwe_responder`

## Requirements
- R1: A register write with chip select low changes no serial state. The output bit position, the reading flag, the bit count and data-out all hold, and only the echoed register bits update.
- R2: A write that raises chip select clears the shifted-in value, the input bit count, the output bit position and the reading flag. Data-out then reads 1.
- R3: With chip select held high, a rising serial clock shifts data-in into the least significant bit of the input value. It also increments the input bit count, which saturates at its maximum.
- R4: With chip select held high, a falling serial clock advances the 10-bit output bit position by one. The position wraps modulo 1024, so word 63 is followed by word 0.
- R5: When the ninth rising clock arrives and no read is active, the first shifted-in three bits form the opcode and the last six bits form the address. The output position is set to address×16−1, and reading is set only when the opcode is binary 110.
- R6: While reading, data-out is bit (15 − pos[3:0]) of word pos[9:4]. After the ninth bit's falling clock, it presents bit 15 of the addressed word. When not reading, data-out is 1.
- R7: The read view always shows present = 1 and grant = 1, plus the last written chip select, clock, data-in and request bits. These echoed bits are 0 after reset.
- R8: A cycle with pr_start high gives pr_done = 1 in the next cycle, with the addressed word on pr_data. A cycle without pr_start gives pr_done = 0 and pr_data = 0 in the next cycle.
- R9: A parallel request with an address above 63 still returns pr_done = 1, with pr_data = 0.
- R10: Words 0 to 2 hold the 48-bit station address, with byte 2i in bits [7:0] of word i and byte 2i+1 in bits [15:8]. Word i for 3 ≤ i ≤ 62 is ((i × 0x0203) mod 65536) XOR 0x1111. Word 63 makes the 16-bit sum of all 64 words equal 0xBABA.
- R11: A single write that raises chip select and also raises the serial clock applies the clear first. The clock edge is then counted as the first input bit.
- R12: A completed 9-bit command with any opcode other than 110 leaves data-out at 1. It stays at 1 through further clocking until chip select rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_cs | input | 1 | Chip select value being written |
| wr_sk | input | 1 | Serial clock value being written |
| wr_di | input | 1 | Serial data-in value being written |
| wr_req | input | 1 | Access request bit being written (echoed only) |
| rd_present | output | 1 | Device present, constant 1 |
| rd_grant | output | 1 | Access granted, constant 1 |
| rd_cs | output | 1 | Last written chip select |
| rd_sk | output | 1 | Last written serial clock |
| rd_di | output | 1 | Last written data-in |
| rd_req | output | 1 | Last written request bit |
| rd_do | output | 1 | Serial data-out |
| pr_start | input | 1 | Parallel word read request |
| pr_addr | input | 8 | Parallel read word address |
| pr_done | output | 1 | Parallel read reply pulse |
| pr_data | output | 16 | Parallel read word |

## Verification
A wrong output bit position shows up as a wrong data-out bit in the cycle after the faulty write. Every address is read for 32 bits, so an error at a word boundary or at the 63-to-0 wrap shows within one clock pulse. A reading flag that is set wrongly turns the constant 1 of an idle or non-read command into data bits at once. A wrong edge order, where chip select rises in the same write as the clock, shifts the whole command by one bit, and the first data-out bit then points at the wrong word. Contents and the out-of-range case are seen on the parallel port one cycle after each request.

// File: rtl/uwe_pkg.sv
package uwe_pkg;
  localparam int unsigned ADDR_W     = 6;
  localparam int unsigned DATA_W     = 16;
  localparam int unsigned OP_W       = 3;
  localparam logic [OP_W-1:0] OP_READ = 3'b110;
  localparam logic [15:0] FILL_MUL   = 16'h0203;
  localparam logic [15:0] FILL_XOR   = 16'h1111;
  localparam logic [15:0] SUM_TARGET = 16'hBABA;
endpackage

// File: rtl/uwe_store.sv
module uwe_store #(
  parameter int unsigned ADDR_W  = uwe_pkg::ADDR_W,
  parameter int unsigned DATA_W  = uwe_pkg::DATA_W,
  parameter logic [47:0] STATION = 48'h665544332211
) (
  input  logic [ADDR_W-1:0] ser_addr,
  output logic [DATA_W-1:0] ser_word,
  input  logic [ADDR_W-1:0] par_addr,
  output logic [DATA_W-1:0] par_word
);
  localparam int unsigned WORDS     = 1 << ADDR_W;
  localparam int unsigned STN_WORDS = 48 / DATA_W;

  function automatic logic [DATA_W-1:0] base_word(input int unsigned i);
    logic [31:0] p;
    if (i < STN_WORDS) return STATION[i*DATA_W +: DATA_W];
    p = i * 32'(uwe_pkg::FILL_MUL);
    return p[DATA_W-1:0] ^ DATA_W'(uwe_pkg::FILL_XOR);
  endfunction

  function automatic logic [DATA_W-1:0] calc_csum();
    logic [DATA_W-1:0] s;
    s = '0;
    for (int unsigned i = 0; i < WORDS - 1; i++) s = s + base_word(i);
    return DATA_W'(uwe_pkg::SUM_TARGET) - s;
  endfunction

  localparam logic [DATA_W-1:0] CSUM_WORD = calc_csum();

  logic [DATA_W-1:0] rom [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    if (g == WORDS - 1) begin : g_sum
      assign rom[g] = CSUM_WORD;
    end else begin : g_base
      assign rom[g] = base_word(unsigned'(g));
    end
  end

  assign ser_word = rom[ser_addr];
  assign par_word = rom[par_addr];
endmodule

// File: rtl/uwe_serial.sv
module uwe_serial #(
  parameter int unsigned ADDR_W = uwe_pkg::ADDR_W,
  parameter int unsigned DATA_W = uwe_pkg::DATA_W,
  localparam int unsigned BIT_W = $clog2(DATA_W),
  localparam int unsigned IDX_W = ADDR_W + BIT_W,
  localparam int unsigned FRAME = uwe_pkg::OP_W + ADDR_W,
  localparam int unsigned CNT_W = $clog2(FRAME + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_cs,
  input  logic             wr_sk,
  input  logic             wr_di,
  output logic             cs_q,
  output logic             sk_q,
  output logic [IDX_W-1:0] out_idx,
  output logic             reading,
  output logic [CNT_W-1:0] in_cnt
);
  logic [FRAME-1:0] val_q, n_val;
  logic [CNT_W-1:0] n_cnt;
  logic [IDX_W-1:0] n_idx;
  logic             n_rd;

  always_comb begin
    n_val = val_q;
    n_cnt = in_cnt;
    n_idx = out_idx;
    n_rd  = reading;
    if (wr_en && wr_cs) begin
      // select rise clears first, then any clock edge in the same write
      if (!cs_q) begin
        n_val = '0;
        n_cnt = '0;
        n_idx = '0;
        n_rd  = 1'b0;
      end
      if (wr_sk != sk_q) begin
        if (!wr_sk) begin
          n_idx = n_idx + IDX_W'(1);
        end else begin
          n_val = {n_val[FRAME-2:0], wr_di};
          if (n_cnt != '1) n_cnt = n_cnt + CNT_W'(1);
          if (n_cnt == CNT_W'(FRAME) && !n_rd) begin
            n_idx = {n_val[ADDR_W-1:0], {BIT_W{1'b0}}} - IDX_W'(1);
            n_rd  = (n_val[FRAME-1 -: uwe_pkg::OP_W] == uwe_pkg::OP_READ);
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= 1'b0;
      sk_q    <= 1'b0;
      val_q   <= '0;
      in_cnt  <= '0;
      out_idx <= '0;
      reading <= 1'b0;
    end else begin
      if (wr_en) begin
        cs_q <= wr_cs;
        sk_q <= wr_sk;
      end
      val_q   <= n_val;
      in_cnt  <= n_cnt;
      out_idx <= n_idx;
      reading <= n_rd;
    end
  end
endmodule

// File: rtl/uwe_pread.sv
module uwe_pread #(
  parameter int unsigned ADDR_W = uwe_pkg::ADDR_W,
  parameter int unsigned DATA_W = uwe_pkg::DATA_W,
  parameter int unsigned REQ_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pr_start,
  input  logic [REQ_AW-1:0] pr_addr,
  output logic [ADDR_W-1:0] par_addr,
  input  logic [DATA_W-1:0] par_word,
  output logic              pr_done,
  output logic [DATA_W-1:0] pr_data
);
  logic in_range;
  assign in_range = (pr_addr[REQ_AW-1:ADDR_W] == '0);
  assign par_addr = pr_addr[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pr_done <= 1'b0;
      pr_data <= '0;
    end else begin
      pr_done <= pr_start;
      pr_data <= (pr_start && in_range) ? par_word : '0;
    end
  end
endmodule

// File: rtl/uwe_responder.sv
module uwe_responder #(
  parameter int unsigned ADDR_W  = uwe_pkg::ADDR_W,
  parameter int unsigned DATA_W  = uwe_pkg::DATA_W,
  parameter int unsigned REQ_AW  = 8,
  parameter logic [47:0] STATION = 48'h665544332211
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_cs,
  input  logic              wr_sk,
  input  logic              wr_di,
  input  logic              wr_req,
  output logic              rd_present,
  output logic              rd_grant,
  output logic              rd_cs,
  output logic              rd_sk,
  output logic              rd_di,
  output logic              rd_req,
  output logic              rd_do,
  input  logic              pr_start,
  input  logic [REQ_AW-1:0] pr_addr,
  output logic              pr_done,
  output logic [DATA_W-1:0] pr_data
);
  localparam int unsigned BIT_W = $clog2(DATA_W);
  localparam int unsigned IDX_W = ADDR_W + BIT_W;
  localparam int unsigned FRAME = uwe_pkg::OP_W + ADDR_W;
  localparam int unsigned CNT_W = $clog2(FRAME + 1);

  logic [IDX_W-1:0]  out_idx;
  logic              reading;
  logic [CNT_W-1:0]  in_cnt;
  logic [DATA_W-1:0] ser_word, par_word;
  logic [ADDR_W-1:0] par_addr;
  logic              di_q, req_q;

  uwe_serial #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_serial (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cs(wr_cs), .wr_sk(wr_sk),
    .wr_di(wr_di), .cs_q(rd_cs), .sk_q(rd_sk), .out_idx(out_idx),
    .reading(reading), .in_cnt(in_cnt)
  );

  uwe_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STATION(STATION)) u_store (
    .ser_addr(out_idx[IDX_W-1:BIT_W]), .ser_word(ser_word),
    .par_addr(par_addr), .par_word(par_word)
  );

  uwe_pread #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REQ_AW(REQ_AW)) u_pread (
    .clk(clk), .rst_n(rst_n), .pr_start(pr_start), .pr_addr(pr_addr),
    .par_addr(par_addr), .par_word(par_word), .pr_done(pr_done),
    .pr_data(pr_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      di_q  <= 1'b0;
      req_q <= 1'b0;
    end else if (wr_en) begin
      di_q  <= wr_di;
      req_q <= wr_req;
    end
  end

  assign rd_present = 1'b1;
  assign rd_grant   = 1'b1;
  assign rd_di      = di_q;
  assign rd_req     = req_q;
  // most significant bit first: bit DATA_W-1-pos[3:0]
  assign rd_do = !reading || ser_word[~out_idx[BIT_W-1:0]];
endmodule

// File: rtl/uwe_chk.sv
module uwe_chk #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned REQ_AW = 8,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_cs,
  input logic              wr_sk,
  input logic              rd_cs,
  input logic              rd_sk,
  input logic              rd_do,
  input logic              rd_present,
  input logic              rd_grant,
  input logic              pr_start,
  input logic [REQ_AW-1:0] pr_addr,
  input logic              pr_done,
  input logic [DATA_W-1:0] pr_data,
  input logic [IDX_W-1:0]  out_idx,
  input logic              reading,
  input logic [CNT_W-1:0]  in_cnt
);
  localparam int unsigned WORDS = 1 << ADDR_W;

  p_cs_low_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_cs |=> $stable(out_idx) && $stable(reading) && $stable(in_cnt));

  p_cs_rise_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_cs && !rd_cs && (wr_sk == rd_sk) |=> out_idx == '0 && !reading && in_cnt == '0);

  p_rise_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_cs && rd_cs && wr_sk && !rd_sk && in_cnt != '1 |=> in_cnt == $past(in_cnt) + CNT_W'(1));

  p_fall_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_cs && rd_cs && !wr_sk && rd_sk |=> out_idx == $past(out_idx) + IDX_W'(1));

  p_idle_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !reading |-> rd_do);

  p_view_const_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_present && rd_grant);

  p_reply_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pr_start |=> pr_done);

  p_no_reply_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pr_start |=> !pr_done && pr_data == '0);

  p_oob_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pr_start && pr_addr >= REQ_AW'(WORDS) |=> pr_done && pr_data == '0);
endmodule

bind uwe_responder uwe_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REQ_AW(REQ_AW), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cs(wr_cs), .wr_sk(wr_sk),
  .rd_cs(rd_cs), .rd_sk(rd_sk), .rd_do(rd_do), .rd_present(rd_present),
  .rd_grant(rd_grant), .pr_start(pr_start), .pr_addr(pr_addr),
  .pr_done(pr_done), .pr_data(pr_data), .out_idx(out_idx),
  .reading(reading), .in_cnt(in_cnt)
);

// File: tb/uwe_responder_bench.sv
module uwe_responder_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [47:0] STN = 48'h665544332211;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, wr_cs = 0, wr_sk = 0, wr_di = 0, wr_req = 0;
  logic rd_present, rd_grant, rd_cs, rd_sk, rd_di, rd_req, rd_do;
  logic pr_start = 0;
  logic [7:0] pr_addr = '0;
  logic pr_done;
  logic [15:0] pr_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [15:0] ew [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  uwe_responder u_uwe_responder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cs(wr_cs), .wr_sk(wr_sk),
    .wr_di(wr_di), .wr_req(wr_req), .rd_present(rd_present), .rd_grant(rd_grant),
    .rd_cs(rd_cs), .rd_sk(rd_sk), .rd_di(rd_di), .rd_req(rd_req), .rd_do(rd_do),
    .pr_start(pr_start), .pr_addr(pr_addr), .pr_done(pr_done), .pr_data(pr_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic cs, input logic sk, input logic di, input logic rq = 1'b0);
    @(negedge clk);
    wr_en = 1; wr_cs = cs; wr_sk = sk; wr_di = di; wr_req = rq;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic send_cmd(input logic [2:0] op, input logic [5:0] a);
    logic [8:0] c;
    c = {op, a};
    for (int b = 8; b >= 0; b--) begin
      wr(1, 1, c[b]);  // R3: rising clock shifts in
      wr(1, 0, c[b]);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 1, 0);
      finish_run();
    end
  end

  initial begin
    logic [15:0] s;
    logic [31:0] p;
    logic [15:0] sum;
    logic [5:0] w;
    logic keep;
    s = 16'h0;
    for (int i = 0; i < 63; i++) begin
      if (i < 3) ew[i] = STN[16*i +: 16];
      else begin
        p = i * 32'h0203;
        ew[i] = p[15:0] ^ 16'h1111;
      end
      s = s + ew[i];
    end
    ew[63] = 16'hBABA - s;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state R7 R6 R8
    chk("R7 reset view", {rd_present, rd_grant, rd_cs, rd_sk, rd_di, rd_req}, 6'b110000);
    chk("R6 reset do", rd_do, 1);
    chk("R8 reset done", pr_done, 0);

    // R7 echo of written bits
    wr(0, 1, 1, 1);
    chk("R7 echo", {rd_present, rd_grant, rd_cs, rd_sk, rd_di, rd_req}, 6'b110111);
    wr(0, 0, 0, 0);
    chk("R7 echo low", {rd_present, rd_grant, rd_cs, rd_sk, rd_di, rd_req}, 6'b110000);

    // R4 R5 R6: every address, 32 bits, crossing into the next word
    for (int a = 0; a < 64; a++) begin
      wr(0, 0, 0);
      wr(1, 0, 0);
      chk("R2 clear do", rd_do, 1);
      send_cmd(3'b110, 6'(a));
      for (int k = 0; k < 32; k++) begin
        w = 6'(a + k / 16);
        chk($sformatf("R6 R4 addr %0d bit %0d", a, k), rd_do, ew[w][15 - (k % 16)]);
        wr(1, 1, 0);
        wr(1, 0, 0);
      end
    end

    // R12: other opcodes keep do at 1
    for (int op = 0; op < 8; op++) begin
      if (op == 6) continue;
      wr(0, 0, 0);
      wr(1, 0, 0);
      send_cmd(3'(op), 6'd5);
      chk($sformatf("R12 op %0d", op), rd_do, 1);
      for (int k = 0; k < 20; k++) begin
        wr(1, 1, 1);
        wr(1, 0, 1);
      end
      chk($sformatf("R12 op %0d later", op), rd_do, 1);
    end

    // R1: clocking with select low leaves the stream where it was
    wr(0, 0, 0);
    wr(1, 0, 0);
    send_cmd(3'b110, 6'd10);
    for (int k = 0; k < 3; k++) begin
      wr(1, 1, 0);
      wr(1, 0, 0);
    end
    chk("R6 before hold", rd_do, ew[10][12]);
    for (int k = 0; k < 5; k++) begin
      wr(0, 1, 1);
      wr(0, 0, 1);
    end
    keep = rd_do;
    chk("R1 select low hold", keep, ew[10][12]);
    wr(1, 0, 0);
    chk("R2 rise clears reading", rd_do, 1);

    // R11: select rise and clock rise in one write
    wr(0, 0, 0);
    wr(1, 1, 1);
    wr(1, 0, 1);
    begin
      logic [7:0] rest;
      rest = {1'b1, 1'b0, 6'd7};
      for (int b = 7; b >= 0; b--) begin
        wr(1, 1, rest[b]);
        wr(1, 0, rest[b]);
      end
    end
    for (int k = 0; k < 4; k++) begin
      chk($sformatf("R11 bit %0d", k), rd_do, ew[7][15 - k]);
      wr(1, 1, 0);
      wr(1, 0, 0);
    end
    wr(0, 0, 0);

    // R8 R9 R10: parallel port sweep
    sum = 16'h0;
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      pr_start = 1; pr_addr = 8'(a);
      @(negedge clk);
      pr_start = 0;
      chk($sformatf("R8 done %0d", a), pr_done, 1);
      if (a < 64) begin
        chk($sformatf("R10 word %0d", a), pr_data, ew[a]);
        sum = sum + pr_data;
      end else begin
        chk($sformatf("R9 oob %0d", a), pr_data, 0);
      end
    end
    @(negedge clk);
    chk("R8 idle", {15'd0, pr_done, pr_data}, 0);
    chk("R10 sum", sum, 16'hBABA);
    chk("R10 station word0", ew[0], 16'h2211);

    finished = 1;
    finish_run();
  end
endmodule